// File: doc/BRIEF.md
# Control Response Rate Selector

This block chooses the transmit rate for a control response frame, such as an acknowledgement or a clear-to-send, that answers a received frame. It takes the received rate index, the station's 12-bit map of basic rates and a band select. It returns the chosen response rate index and, for OFDM responses, the 8-bit PHY signal code and the 8-bit reserve time that the transmit path needs. It also reports the highest basic CCK rate, the highest basic OFDM rate, and whether any OFDM rate is in the basic map.

Rate indices 0 to 3 are the CCK rates 1, 2, 5.5 and 11 Mb/s. Indices 4 to 11 are the OFDM rates 6, 9, 12, 18, 24, 36, 48 and 54 Mb/s. Bit n of the basic map marks index n as basic. A request strobe captures one lookup. A two-state machine has the states `ST_IDLE` and `ST_RESP`. The transition `T_ACCEPT` (a strobe in either state) enters `ST_RESP`, and `T_DRAIN` (no strobe while in `ST_RESP`) returns to `ST_IDLE`. The result is shown for the one cycle spent in `ST_RESP` and is held after that.

Top module: `rsp_rate_sel`

## Requirements
- R1: After reset `rsp_valid` is 0 and `rsp_rate`, `rate_code`, `rsv_time`, `top_cck`, `top_ofdm` and `ofdm_basic` are all 0.
- R2: `rsp_valid` is 1 in the cycle after each cycle with `req_valid` high and 0 otherwise. Without a request all result outputs hold their last value.
- R3: When the received index is 0 to 3 (CCK), the response index is the highest basic index from 1 up to the received index. If there is none, it is 0.
- R4: When the received index is 4 or more and bits 11:4 of the basic map are all 0, the response index is the received index limited to at most 8 (24 Mb/s).
- R5: When the received index is 4 or more and some bit in 11:4 is set, the response index is the highest basic index from 4 up to the received index. If there is none, it is 8.
- R6: Received indices 12 to 15 behave like index 11 in R5 (the 72 Mb/s slot reuses the 54 Mb/s result). The response index never exceeds 11.
- R7: With `band_5g`=1, OFDM response indices 4..11 give the rate codes 0x9B, 0x9F, 0x9A, 0x9E, 0x99, 0x9D, 0x98, 0x9C.
- R8: With `band_5g`=0, the rate code is the R7 value with bit 4 cleared (for example 0x8B for index 4).
- R9: The reserve time for indices 4..11 is 44, 36, 32, 28, 28, 24, 24, 24 with `band_5g`=1, and each value plus 6 with `band_5g`=0.
- R10: A CCK response (response index below 4) gives `rate_code`=0 and `rsv_time`=0.
- R11: `top_cck` is the highest set bit in 3:0, or 0 if there is none. `top_ofdm` is the highest set bit in 11:4, or 8 if there is none. `ofdm_basic` is 1 when any bit in 11:4 is set. All three are captured with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Capture a lookup this cycle |
| basic_map | input | 12 | Basic-rate bitmap, bit n = rate index n |
| band_5g | input | 1 | 1 = 5 GHz code set, 0 = 2.4 GHz code set |
| rx_rate | input | 4 | Received frame rate index |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_rate | output | 4 | Chosen response rate index |
| rate_code | output | 8 | OFDM PHY signal code, 0 for CCK |
| rsv_time | output | 8 | OFDM reserve time, 0 for CCK |
| top_cck | output | 4 | Highest basic CCK index |
| top_ofdm | output | 4 | Highest basic OFDM index |
| ofdm_basic | output | 1 | Some OFDM rate is basic |

## Verification
The assertions assume that the inputs are stable when a strobe is sampled and that the received index fits in 4 bits. With that, every value of the index from 0 to 15 is legal, including the out-of-range values 12 to 15. The random stimulus draws the full 4-bit index, the full 12-bit map and both bands. Maps are biased toward empty OFDM halves and toward a single set bit, so that the fallback paths run often. Directed vectors cover the empty map, indices 12 to 15, and every OFDM index in both bands.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
    localparam int NUM_RATES   = 12;
    localparam int IDX_W       = 4;
    localparam int CCK_HI      = 3;
    localparam int OFDM_LO     = 4;
    localparam int OFDM_HI     = NUM_RATES - 1;
    localparam int OFDM_DFLT   = 8;
    localparam int CODE_W      = 8;
    localparam int BAND_OFFSET = 6;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsel_state_e;

    typedef struct packed {
        logic [IDX_W-1:0]  rate;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] rsv;
        logic [IDX_W-1:0]  top_cck;
        logic [IDX_W-1:0]  top_ofdm;
        logic              ofdm_any;
    } rsel_result_t;
endpackage

// File: rtl/rsel_scan.sv
module rsel_scan #(
    parameter int MAP_W = 12,
    parameter int IDX_W = 4,
    parameter int LO    = 0,
    parameter int HI    = 3,
    parameter int DFLT  = 0
) (
    input  logic [MAP_W-1:0] map,
    input  logic [IDX_W-1:0] start,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    // Ascending walk: the last match inside the window is the highest one.
    always_comb begin
        hit = 1'b0;
        idx = IDX_W'(DFLT);
        for (int i = LO; i <= HI; i++) begin
            if (map[i] && (i <= int'(start))) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rsel_code.sv
module rsel_code
    import rsel_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic              band_5g,
    output logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] rsv
);
    logic [CODE_W-1:0] code_hi;
    logic [CODE_W-1:0] rsv_hi;

    always_comb begin
        unique case (idx)
            4'd4:    begin code_hi = 8'h9B; rsv_hi = 8'd44; end
            4'd5:    begin code_hi = 8'h9F; rsv_hi = 8'd36; end
            4'd6:    begin code_hi = 8'h9A; rsv_hi = 8'd32; end
            4'd7:    begin code_hi = 8'h9E; rsv_hi = 8'd28; end
            4'd9:    begin code_hi = 8'h9D; rsv_hi = 8'd24; end
            4'd10:   begin code_hi = 8'h98; rsv_hi = 8'd24; end
            4'd11:   begin code_hi = 8'h9C; rsv_hi = 8'd24; end
            default: begin code_hi = 8'h99; rsv_hi = 8'd28; end
        endcase
    end

    assign code = band_5g ? code_hi : (code_hi & ~8'h10);
    assign rsv  = band_5g ? rsv_hi  : (rsv_hi + CODE_W'(BAND_OFFSET));
endmodule

// File: rtl/rsp_rate_sel.sv
module rsp_rate_sel
    import rsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [NUM_RATES-1:0] basic_map,
    input  logic                 band_5g,
    input  logic [IDX_W-1:0]     rx_rate,
    output logic                 rsp_valid,
    output logic [IDX_W-1:0]     rsp_rate,
    output logic [CODE_W-1:0]    rate_code,
    output logic [CODE_W-1:0]    rsv_time,
    output logic [IDX_W-1:0]     top_cck,
    output logic [IDX_W-1:0]     top_ofdm,
    output logic                 ofdm_basic
);
    localparam logic [IDX_W-1:0] FULL_START = '1;
    localparam logic [IDX_W-1:0] CLAMP_IDX  = IDX_W'(OFDM_DFLT);

    rsel_state_e  state_q, state_d;
    rsel_result_t res_q, res_d;

    logic [IDX_W-1:0]  cck_idx, ofdm_idx, tcck_idx, tofdm_idx;
    logic              cck_hit, ofdm_hit, tcck_hit, any_ofdm;
    logic              rx_is_cck;
    logic [IDX_W-1:0]  pick;
    logic [CODE_W-1:0] lut_code, lut_rsv;

    rsel_scan #(.MAP_W(NUM_RATES), .IDX_W(IDX_W), .LO(1), .HI(CCK_HI), .DFLT(0))
        u_cck_scan (.map(basic_map), .start(rx_rate), .idx(cck_idx), .hit(cck_hit));

    rsel_scan #(.MAP_W(NUM_RATES), .IDX_W(IDX_W), .LO(OFDM_LO), .HI(OFDM_HI), .DFLT(OFDM_DFLT))
        u_ofdm_scan (.map(basic_map), .start(rx_rate), .idx(ofdm_idx), .hit(ofdm_hit));

    rsel_scan #(.MAP_W(NUM_RATES), .IDX_W(IDX_W), .LO(0), .HI(CCK_HI), .DFLT(0))
        u_top_cck (.map(basic_map), .start(FULL_START), .idx(tcck_idx), .hit(tcck_hit));

    rsel_scan #(.MAP_W(NUM_RATES), .IDX_W(IDX_W), .LO(OFDM_LO), .HI(OFDM_HI), .DFLT(OFDM_DFLT))
        u_top_ofdm (.map(basic_map), .start(FULL_START), .idx(tofdm_idx), .hit(any_ofdm));

    assign rx_is_cck = (rx_rate <= IDX_W'(CCK_HI));

    always_comb begin
        if (rx_is_cck)
            pick = cck_idx;
        else if (any_ofdm)
            pick = ofdm_idx;
        else
            pick = (rx_rate > CLAMP_IDX) ? CLAMP_IDX : rx_rate;
    end

    rsel_code u_code (.idx(pick), .band_5g(band_5g), .code(lut_code), .rsv(lut_rsv));

    always_comb begin
        res_d          = res_q;
        res_d.rate     = pick;
        res_d.code     = rx_is_cck ? '0 : lut_code;
        res_d.rsv      = rx_is_cck ? '0 : lut_rsv;
        res_d.top_cck  = tcck_idx;
        res_d.top_ofdm = tofdm_idx;
        res_d.ofdm_any = any_ofdm;
    end

    // next state: T_ACCEPT on strobe, T_DRAIN otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         res_q <= '0;
        else if (req_valid) res_q <= res_d;
    end

    assign rsp_valid  = (state_q == ST_RESP);
    assign rsp_rate   = res_q.rate;
    assign rate_code  = res_q.code;
    assign rsv_time   = res_q.rsv;
    assign top_cck    = res_q.top_cck;
    assign top_ofdm   = res_q.top_ofdm;
    assign ofdm_basic = res_q.ofdm_any;
endmodule

// File: rtl/rsp_rate_sel_chk.sv
module rsp_rate_sel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [11:0] basic_map,
    input logic        band_5g,
    input logic [3:0]  rx_rate,
    input logic        rsp_valid,
    input logic [3:0]  rsp_rate,
    input logic [7:0]  rate_code,
    input logic [7:0]  rsv_time,
    input logic [3:0]  top_cck,
    input logic [3:0]  top_ofdm,
    input logic        ofdm_basic
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_rate) && $stable(rate_code) && $stable(rsv_time) && $stable(top_ofdm))); // R2
    AST_CCK_DOWNWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rx_rate < 4'd4) |=> (rsp_rate <= $past(rx_rate))); // R3
    AST_NO_BASIC_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rx_rate >= 4'd4 && basic_map[11:4] == 8'h00)
        |=> (rsp_rate == (($past(rx_rate) > 4'd8) ? 4'd8 : $past(rx_rate)))); // R4
    AST_RATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rate <= 4'd11)); // R6
    AST_BAND_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rx_rate >= 4'd4) |=> (rate_code[7] && (rate_code[4] == $past(band_5g)))); // R8
    AST_CCK_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_rate < 4'd4) |-> (rate_code == 8'h00 && rsv_time == 8'h00)); // R10
    AST_TOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (top_ofdm >= 4'd4 && top_ofdm <= 4'd11 && top_cck <= 4'd3)); // R11
endmodule

bind rsp_rate_sel rsp_rate_sel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .basic_map(basic_map),
    .band_5g(band_5g), .rx_rate(rx_rate), .rsp_valid(rsp_valid), .rsp_rate(rsp_rate),
    .rate_code(rate_code), .rsv_time(rsv_time), .top_cck(top_cck),
    .top_ofdm(top_ofdm), .ofdm_basic(ofdm_basic)
);

// File: tb/rsp_rate_sel_tb.sv
module rsp_rate_sel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] basic_map = '0;
    logic        band_5g = 1'b0;
    logic [3:0]  rx_rate = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_rate, top_cck, top_ofdm;
    logic [7:0]  rate_code, rsv_time;
    logic        ofdm_basic;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rsp_rate_sel u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .basic_map(basic_map),
        .band_5g(band_5g), .rx_rate(rx_rate), .rsp_valid(rsp_valid), .rsp_rate(rsp_rate),
        .rate_code(rate_code), .rsv_time(rsv_time), .top_cck(top_cck),
        .top_ofdm(top_ofdm), .ofdm_basic(ofdm_basic)
    );

    function automatic logic [3:0] exp_rate(logic [11:0] m, logic [3:0] rx);
        int r;
        r = int'(rx);
        if (r <= 3) begin
            for (int k = r; k >= 1; k--) if (m[k]) return 4'(k);
            return 4'd0;
        end
        if (m[11:4] == 8'h00) return (r > 8) ? 4'd8 : rx;
        if (r > 11) r = 11;
        for (int k = r; k >= 4; k--) if (m[k]) return 4'(k);
        return 4'd8;
    endfunction

    function automatic logic [15:0] exp_code_rsv(logic [3:0] idx, logic b5);
        logic [7:0] c, t;
        case (idx)
            4'd4: begin c = 8'h9B; t = 8'd44; end
            4'd5: begin c = 8'h9F; t = 8'd36; end
            4'd6: begin c = 8'h9A; t = 8'd32; end
            4'd7: begin c = 8'h9E; t = 8'd28; end
            4'd8: begin c = 8'h99; t = 8'd28; end
            4'd9: begin c = 8'h9D; t = 8'd24; end
            4'd10: begin c = 8'h98; t = 8'd24; end
            4'd11: begin c = 8'h9C; t = 8'd24; end
            default: begin c = 8'h00; t = 8'h00; end
        endcase
        if (idx >= 4'd4 && !b5) begin c[4] = 1'b0; t = t + 8'd6; end
        return {c, t};
    endfunction

    function automatic logic [8:0] exp_tops(logic [11:0] m);
        logic [3:0] tc, to;
        tc = 4'd0; to = 4'd8;
        for (int k = 0; k <= 3; k++) if (m[k]) tc = 4'(k);
        for (int k = 4; k <= 11; k++) if (m[k]) to = 4'(k);
        return {tc, to, |m[11:4]};
    endfunction

    task automatic apply(input logic [11:0] m, input logic b5, input logic [3:0] rx, input string tag);
        logic [3:0]  er;
        logic [15:0] cr;
        logic [8:0]  tp;
        @(negedge clk);
        basic_map = m; band_5g = b5; rx_rate = rx; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        er = exp_rate(m, rx);
        cr = exp_code_rsv(er, b5);
        if (rx <= 4'd3) cr = 16'h0000;
        tp = exp_tops(m);
        checks++;
        if (!rsp_valid || rsp_rate !== er || {rate_code, rsv_time} !== cr ||
            {top_cck, top_ofdm, ofdm_basic} !== tp) begin
            fails++;
            $display("FAIL %s map=%h b5=%0d rx=%0d: got v=%0d r=%0d c=%h t=%0d tops=%h exp r=%0d c=%h t=%0d tops=%h",
                     tag, m, b5, rx, rsp_valid, rsp_rate, rate_code, rsv_time,
                     {top_cck, top_ofdm, ofdm_basic}, er, cr[15:8], cr[7:0], tp);
        end
    endtask

    // R2: idle cycle with changed inputs must drop valid and keep results
    task automatic check_hold();
        logic [3:0] r0; logic [7:0] c0, t0;
        r0 = rsp_rate; c0 = rate_code; t0 = rsv_time;
        basic_map = ~basic_map; rx_rate = rx_rate ^ 4'd5; band_5g = ~band_5g;
        @(negedge clk);
        checks++;
        if (rsp_valid || rsp_rate !== r0 || rate_code !== c0 || rsv_time !== t0) begin
            fails++;
            $display("FAIL R2 hold: got v=%0d r=%0d c=%h t=%0d exp v=0 r=%0d c=%h t=%0d",
                     rsp_valid, rsp_rate, rate_code, rsv_time, r0, c0, t0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] m;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if (rsp_valid !== 1'b0 || rsp_rate !== 4'd0 || rate_code !== 8'd0 || rsv_time !== 8'd0 ||
            top_cck !== 4'd0 || top_ofdm !== 4'd0 || ofdm_basic !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got v=%0d r=%0d c=%h t=%0d exp all zero",
                     rsp_valid, rsp_rate, rate_code, rsv_time);
        end
        rst_n = 1'b1;

        apply(12'h000, 1'b1, 4'd3, "R3 empty map");
        apply(12'h005, 1'b1, 4'd3, "R3 scan down to 2");
        apply(12'h008, 1'b0, 4'd2, "R3/R10 above rx ignored");
        check_hold();
        apply(12'h00F, 1'b0, 4'd11, "R4 clamp to 24");
        apply(12'h000, 1'b1, 4'd6, "R4 below clamp");
        apply(12'h400, 1'b1, 4'd5, "R5 no match fallback");
        apply(12'h0A0, 1'b0, 4'd9, "R5 scan to 7");
        apply(12'h800, 1'b1, 4'd15, "R6 idx15 as 54");
        apply(12'h800, 1'b0, 4'd12, "R6 72 slot");
        for (int k = 4; k <= 11; k++) begin
            apply(12'hFF0, 1'b1, 4'(k), "R7/R9 5G table");
            apply(12'hFF0, 1'b0, 4'(k), "R8/R9 2G table");
        end
        apply(12'h00A, 1'b0, 4'd0, "R11 tops");
        check_hold();

        for (int n = 0; n < 400; n++) begin
            m = 12'($urandom);
            case ($urandom % 4)
                0: m[11:4] = 8'h00;
                1: m = 12'h001 << ($urandom % 12);
                default: ;
            endcase
            apply(m, 1'($urandom), 4'($urandom), "R3-R11 random");
            if (n % 37 == 0) check_hold();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule